// File: doc/BRIEF.md
# Interpolating Sine/Cosine Frequency Synthesizer

A direct digital frequency synthesizer that generates a quadrature pair of signed sine and cosine samples. A 20-bit phase register advances by a programmable frequency control word on every enabled clock and wraps modulo 2^20, so at a 30 MHz clock one code step is roughly 28.6 Hz.

Amplitude is not read from a large table. A quarter wave is held as 16 segment start points plus an end point at full scale. The two points that bracket the phase are blended linearly using the low phase bits as the weight. Quadrant folding reuses the quarter wave for the full cycle. The cosine channel runs the same datapath on the phase advanced by a quarter turn.

Top module: `dds_interp_synth`

## Requirements
- R1: While rst_ni is low, sin_o, cos_o and valid_o are all 0.
- R2: On each rising clock edge with en_i high, the phase advances by fcw_i modulo 2^20. An fcw_i of 2^20-1 therefore steps the phase backwards by one code.
- R3: The quarter-wave table has 17 unsigned points. Point k equals round(255*sin(k*pi/32)) for k = 0..16. Phase bits [19:18] give the quadrant, bits [17:14] the table index k, and bits [13:0] the weight f.
- R4: The magnitude is y(k) + floor((y(k+1) - y(k)) * f / 2^14), saturated to the signed 9-bit range.
- R5: When phase bit 18 is set, bits [17:0] are bit-inverted before the index and weight are taken. When phase bit 19 is set, the magnitude is negated.
- R6: cos_o is the R3 to R5 result for the phase plus 2^18, modulo 2^20.
- R7: After an enabled edge, the outputs show the value for the phase the accumulator held two enabled edges earlier. valid_o rises on the second enabled edge after reset and then stays high.
- R8: While en_i is low, the phase, sin_o, cos_o and valid_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance enable for the accumulator and the pipeline |
| fcw_i | input | 20 | Frequency control word (phase step) |
| sin_o | output | 9 | Signed sine sample |
| cos_o | output | 9 | Signed cosine sample |
| valid_o | output | 1 | High once the pipeline holds real samples |

## Verification
The bench drives a control word of exactly one table step. This walks every stored point and every quadrant boundary. An off-by-one in the end point or in the inverted-phase lookup would show as a wrong value at 0 or 90 degrees, for example a cosine of 255 instead of 254 at zero phase.

Half-step and random control words exercise the interpolation weight. A design that rounds instead of truncating, or that negates in the wrong quadrant, disagrees with the bench model there. The bench also tests a backwards step, to check wrap-around, and stretches of disabled cycles. A design that lets the phase drift or the outputs change while disabled misaligns every later sample. A reset in mid-run checks that the fill count and valid_o restart.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int AMP_W  = 9;             // signed output width
  localparam int IDX_W  = 4;             // 16 quarter-wave segments
  localparam int MAG_W  = AMP_W - 1;     // unsigned table magnitude
  localparam int NPTS   = (1 << IDX_W) + 1;
  localparam int PIPE_LAT = 2;

  typedef logic [MAG_W-1:0]        mag_t;
  typedef logic signed [AMP_W-1:0] amp_t;
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int PHASE_W = 20,
  parameter int LAT     = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PHASE_W-1:0] fcw_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               valid_o
);
  localparam int CNT_W = $clog2(LAT + 1);

  logic [PHASE_W-1:0] phase_q;
  logic [CNT_W-1:0]   fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      fill_q  <= '0;
    end else if (en_i) begin
      phase_q <= phase_q + fcw_i;
      if (fill_q != CNT_W'(LAT)) fill_q <= fill_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
  assign valid_o = (fill_q == CNT_W'(LAT));

  assert_phase_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(phase_q));
  assert_valid_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
endmodule

// File: rtl/dds_quarter_lut.sv
module dds_quarter_lut
  import dds_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  output mag_t             y0_o,
  output mag_t             y1_o
);
  function automatic mag_t point(input logic [IDX_W:0] k);
    case (k)
      5'd0:  point = 8'd0;
      5'd1:  point = 8'd25;
      5'd2:  point = 8'd50;
      5'd3:  point = 8'd74;
      5'd4:  point = 8'd98;
      5'd5:  point = 8'd120;
      5'd6:  point = 8'd142;
      5'd7:  point = 8'd162;
      5'd8:  point = 8'd180;
      5'd9:  point = 8'd197;
      5'd10: point = 8'd212;
      5'd11: point = 8'd225;
      5'd12: point = 8'd236;
      5'd13: point = 8'd244;
      5'd14: point = 8'd250;
      5'd15: point = 8'd254;
      default: point = 8'd255;   // 90 degree end point
    endcase
  endfunction

  assign y0_o = point({1'b0, idx_i});
  assign y1_o = point({1'b0, idx_i} + 1'b1);
endmodule

// File: rtl/dds_fold.sv
module dds_fold
  import dds_pkg::*;
#(
  parameter int PHASE_W = 20
) (
  input  logic [PHASE_W-1:0]          phase_i,
  output mag_t                        y0_o,
  output mag_t                        y1_o,
  output logic [PHASE_W-3-IDX_W:0]    frac_o,
  output logic                        neg_o
);
  localparam int QPH_W  = PHASE_W - 2;
  localparam int FRAC_W = QPH_W - IDX_W;

  logic [QPH_W-1:0] qph;
  logic [IDX_W-1:0] idx;

  // odd quadrants run the quarter wave backwards
  assign qph    = phase_i[QPH_W] ? ~phase_i[QPH_W-1:0] : phase_i[QPH_W-1:0];
  assign idx    = qph[QPH_W-1 -: IDX_W];
  assign frac_o = qph[FRAC_W-1:0];
  assign neg_o  = phase_i[PHASE_W-1];

  dds_quarter_lut i_lut (
    .idx_i (idx),
    .y0_o  (y0_o),
    .y1_o  (y1_o)
  );
endmodule

// File: rtl/dds_interp.sv
module dds_interp
  import dds_pkg::*;
#(
  parameter int FRAC_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  mag_t              y0_i,
  input  mag_t              y1_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              neg_i,
  output amp_t              amp_o
);
  localparam int PROD_W = MAG_W + FRAC_W;
  localparam logic signed [AMP_W:0] LIM_HI = (AMP_W+1)'((1 << (AMP_W-1)) - 1);
  localparam logic signed [AMP_W:0] LIM_LO = ~LIM_HI;

  mag_t              y0_q, y1_q;
  logic [FRAC_W-1:0] frac_q;
  logic              neg_q;
  amp_t              amp_q;

  mag_t                   diff;
  logic [PROD_W-1:0]      prod;
  logic [MAG_W:0]         mag;
  logic signed [AMP_W:0]  sval;
  amp_t                   sat;

  assign diff = y1_q - y0_q;
  assign prod = {{FRAC_W{1'b0}}, diff} * {{MAG_W{1'b0}}, frac_q};
  assign mag  = {1'b0, y0_q} + {1'b0, prod[PROD_W-1:FRAC_W]};
  assign sval = neg_q ? -$signed({1'b0, mag}) : $signed({1'b0, mag});

  always_comb begin
    if (sval > LIM_HI)      sat = LIM_HI[AMP_W-1:0];
    else if (sval < LIM_LO) sat = LIM_LO[AMP_W-1:0];
    else                    sat = sval[AMP_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y0_q   <= '0;
      y1_q   <= '0;
      frac_q <= '0;
      neg_q  <= 1'b0;
      amp_q  <= '0;
    end else if (en_i) begin
      y0_q   <= y0_i;
      y1_q   <= y1_i;
      frac_q <= frac_i;
      neg_q  <= neg_i;
      amp_q  <= sat;
    end
  end

  assign amp_o = amp_q;

  assert_lut_monotone_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y1_q >= y0_q);
  assert_out_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(amp_q));
endmodule

// File: rtl/dds_interp_synth.sv
module dds_interp_synth
  import dds_pkg::*;
#(
  parameter int PHASE_W = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PHASE_W-1:0] fcw_i,
  output logic [AMP_W-1:0]   sin_o,
  output logic [AMP_W-1:0]   cos_o,
  output logic               valid_o
);
  localparam int FRAC_W = PHASE_W - 2 - IDX_W;
  localparam logic [PHASE_W-1:0] QUARTER = PHASE_W'(1) << (PHASE_W - 2);

  logic [PHASE_W-1:0] phase;
  amp_t               samp [2];

  dds_phase_acc #(.PHASE_W(PHASE_W), .LAT(PIPE_LAT)) i_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .fcw_i   (fcw_i),
    .phase_o (phase),
    .valid_o (valid_o)
  );

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic [PHASE_W-1:0] ph;
    mag_t               y0, y1;
    logic [FRAC_W-1:0]  frac;
    logic               neg;

    // channel 1 (cosine) leads by a quarter turn
    assign ph = (ch == 0) ? phase : phase + QUARTER;

    dds_fold #(.PHASE_W(PHASE_W)) i_fold (
      .phase_i (ph),
      .y0_o    (y0),
      .y1_o    (y1),
      .frac_o  (frac),
      .neg_o   (neg)
    );

    dds_interp #(.FRAC_W(FRAC_W)) i_interp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .y0_i   (y0),
      .y1_i   (y1),
      .frac_i (frac),
      .neg_i  (neg),
      .amp_o  (samp[ch])
    );
  end

  assign sin_o = samp[0];
  assign cos_o = samp[1];

  assert_quadrature_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && phase == '0) |-> (g_chan[1].neg == 1'b0));
  assert_valid_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(valid_o));
endmodule

// File: tb/test_dds_interp_synth.sv
module test_dds_interp_synth;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [19:0] fcw = '0;
  logic [8:0]  sin_s, cos_s;
  logic        valid;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  dds_interp_synth i_dds_interp_synth (
    .clk_i (clk), .rst_ni (rst_n), .en_i (en), .fcw_i (fcw),
    .sin_o (sin_s), .cos_o (cos_s), .valid_o (valid)
  );

  // phase history seen by the bench
  logic [19:0] m_acc, m_p1, m_p2;
  int          m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc <= '0; m_p1 <= '0; m_p2 <= '0; m_cnt <= 0;
    end else if (en) begin
      m_acc <= m_acc + fcw;
      m_p1  <= m_acc;
      m_p2  <= m_p1;
      if (m_cnt < 2) m_cnt <= m_cnt + 1;
    end
  end

  function automatic int tab(int k);
    real x;
    x = 255.0 * $sin(k * 3.14159265358979 / 32.0);
    return $rtoi(x + 0.5);
  endfunction

  function automatic int wave(logic [19:0] ph);
    logic [17:0] p;
    int k, f, v;
    p = ph[18] ? ~ph[17:0] : ph[17:0];
    k = int'(p[17:14]);
    f = int'(p[13:0]);
    v = tab(k) + ((tab(k + 1) - tab(k)) * f) / 16384;
    if (ph[19]) v = -v;
    if (v > 255) v = 255;
    if (v < -256) v = -256;
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compare(string req);
    int es, ec, ev;
    es = (m_cnt >= 2) ? wave(m_p2) : 0;
    ec = (m_cnt >= 2) ? wave(m_p2 + 20'h40000) : 0;
    ev = (m_cnt >= 2) ? 1 : 0;
    check({req, " sin"}, int'($signed(sin_s)), es);
    check({req, " cos"}, int'($signed(cos_s)), ec);
    check({req, " valid"}, int'(valid), ev);
  endtask

  task automatic run(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare(req);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <= 100000 cycles", cyc);
      summary();
    end
  end

  initial begin
    int sin_h, cos_h;
    void'($urandom(32'd1234));
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 sin", int'($signed(sin_s)), 0);
    check("R1 cos", int'($signed(cos_s)), 0);
    check("R1 valid", int'(valid), 0);
    rst_n = 1'b1;

    // R7 fill with zero step, R6 cosine at phase 0 is 254
    en = 1'b1; fcw = '0;
    @(negedge clk);
    check("R7 valid after one edge", int'(valid), 0);
    @(negedge clk);
    check("R7 valid after two edges", int'(valid), 1);
    check("R6 cos at zero phase", int'($signed(cos_s)), 254);
    check("R3 sin at zero phase", int'($signed(sin_s)), 0);

    // R3 R5 R6 one table step per cycle, two full turns
    fcw = 20'h04000;
    run(140, "R3 R5 table walk");
    // R4 half-step weight
    fcw = 20'h02000;
    run(140, "R4 half step");
    fcw = 20'h00123;
    run(60, "R4 fine step");
    // R2 backwards step across the wrap
    fcw = 20'hFFFFF;
    run(40, "R2 wrap");
    fcw = 20'h80000;
    run(10, "R5 half turn");

    // R8 hold while disabled
    fcw = 20'h0ABCD;
    run(5, "R2 step");
    @(negedge clk);
    en = 1'b0; fcw = 20'h3FFFF;
    sin_h = int'($signed(sin_s)); cos_h = int'($signed(cos_s));
    repeat (10) @(negedge clk);
    check("R8 sin held", int'($signed(sin_s)), sin_h);
    check("R8 cos held", int'($signed(cos_s)), cos_h);
    check("R8 valid held", int'(valid), 1);
    en = 1'b1; fcw = 20'h0ABCD;
    run(5, "R8 phase kept");

    // random mix
    for (int blk = 0; blk < 30; blk++) begin
      fcw = 20'($urandom);
      for (int i = 0; i < 50; i++) begin
        en = ($urandom % 5) != 0;
        @(negedge clk);
        compare("R2 R4 random");
      end
    end

    // R1 R7 reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    compare("R1 mid-run reset");
    rst_n = 1'b1; en = 1'b1;
    run(20, "R7 refill");

    summary();
  end
endmodule